// File: doc/BRIEF.md
# Dual-Shape Two-Port Memory Tile

This block holds 256 bits of storage. A write port and a read port work side by side, and each port has its own address. A static shape input sets the organisation. With the input low, the tile holds 32 words of 8 bits. With it high, the same bits are seen as 64 words of 4 bits. In the narrow shape each 4-bit word sits in one half of an 8-bit storage row. A narrow write changes only that half. Changing the shape never clears the stored bits, so data written in one shape can be read back in the other.

Reads are registered. The word appears on the output one clock after the read is requested, and it stays there until the next read. A block-select input gates both ports. This lets several tiles be stacked to make a deeper memory. A tile that is not selected ignores writes and loads zero on a read, so the outputs of all tiles in a stack can simply be ORed together. To make a wider memory, tiles are placed side by side with their addresses shared.

Top module: `shape_ram`

## Requirements
- R1: With `mode_narrow`=0, a write stores all 8 bits of `wr_data` at row `wr_addr[4:0]`. A later read of that row returns the same 8 bits. Address bit 5 is ignored in this shape.
- R2: With `mode_narrow`=1, address bits [5:1] pick the row and address bit 0 picks the half: 0 is bits [3:0] and 1 is bits [7:4]. A read returns the selected half in `rd_data[3:0]`, with `rd_data[7:4]` equal to zero.
- R3: A narrow write stores `wr_data[3:0]` into the selected half and leaves the other half of that row unchanged.
- R4: `rd_data` takes the new word at the rising edge where `rd_en`=1 is sampled, and not before.
- R5: While `rd_en`=0, `rd_data` holds its value whatever the read address does.
- R6: A read and a write to the same location in one cycle return the contents from before the write. The write still takes effect.
- R7: With `blk_sel`=0, a write is ignored, and a read loads zero into `rd_data`.
- R8: Changing `mode_narrow` leaves the stored contents unchanged.
- R9: While `rst_n` is low, `rd_data` is cleared to zero at each clock edge.
- R10: A write and a read to different locations in the same cycle both complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the read register |
| mode_narrow | input | 1 | Shape: 0 = 32x8, 1 = 64x4 (static) |
| blk_sel | input | 1 | Tile select for depth stacking |
| wr_en | input | 1 | Write request |
| wr_addr | input | 6 | Write address |
| wr_data | input | 8 | Write data (bits [3:0] in narrow shape) |
| rd_en | input | 1 | Read request |
| rd_addr | input | 6 | Read address |
| rd_data | output | 8 | Registered read word, zero when loaded while deselected |

## Verification
The hardest case to reach is a narrow write that lands beside existing data. It has to be shown from the ports that the other half of the row survives. To do this, the bench fills a row in the wide shape, switches to the narrow shape, and writes a single nibble. It then switches back to the wide shape and reads the whole row, which exposes both halves at once. The same-cycle collision is reached by driving both ports at one address on the same edge. A read that follows then confirms that the write was kept.

// File: rtl/shape_ram_pkg.sv
// Package: shared types for the dual-shape memory tile.
// Assumes the storage row is split into exactly two equal lanes.
package shape_ram_pkg;
    typedef enum logic {
        SHAPE_WIDE   = 1'b0,
        SHAPE_NARROW = 1'b1
    } shape_e;

    localparam int LANES = 2;
endpackage

// File: rtl/shape_ram_decode.sv
// Address decoder: turns a port address into a storage row and a lane index.
// Assumes the narrow shape has twice as many words as the wide shape.
module shape_ram_decode
    import shape_ram_pkg::*;
#(
    parameter int ROW_AW = 5
) (
    input  shape_e              shape,
    input  logic [ROW_AW:0]     addr,
    output logic [ROW_AW-1:0]   row,
    output logic                lane
);
    // Pick the row bits and the lane bit for the current shape.
    always_comb begin
        if (shape == SHAPE_NARROW) begin
            row  = addr[ROW_AW:1];
            lane = addr[0];
        end else begin
            row  = addr[ROW_AW-1:0];
            lane = 1'b0;
        end
    end
endmodule

// File: rtl/shape_ram_array.sv
// Storage array: rows of two lanes, each lane with its own write enable.
// Assumes no reset of contents; reads are combinational (asynchronous).
module shape_ram_array
    import shape_ram_pkg::*;
#(
    parameter int ROWS   = 32,
    parameter int ROW_W  = 8,
    parameter int ROW_AW = $clog2(ROWS)
) (
    input  logic                clk,
    input  logic [ROW_AW-1:0]   wr_row,
    input  logic [LANES-1:0]    wr_lane_en,
    input  logic [ROW_W-1:0]    wr_word,
    input  logic [ROW_AW-1:0]   rd_row,
    output logic [ROW_W-1:0]    rd_word
);
    localparam int LANE_W = ROW_W / LANES;

    logic [LANE_W-1:0] mem [LANES][ROWS];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Write one lane of the addressed row when its enable is set.
        always_ff @(posedge clk) begin
            if (wr_lane_en[g]) begin
                mem[g][wr_row] <= wr_word[g*LANE_W +: LANE_W];
            end
        end

        // Present the addressed row's lane to the read side.
        always_comb begin
            rd_word[g*LANE_W +: LANE_W] = mem[g][rd_row];
        end
    end
endmodule

// File: rtl/shape_ram_rdport.sv
// Read port register: formats the row word for the shape and holds it.
// Assumes select and enable are already resolved by the caller.
module shape_ram_rdport
    import shape_ram_pkg::*;
#(
    parameter int ROW_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  shape_e            shape,
    input  logic              lane,
    input  logic              rd_en,
    input  logic              sel,
    input  logic [ROW_W-1:0]  row_word,
    output logic [ROW_W-1:0]  rd_data
);
    localparam int LANE_W = ROW_W / LANES;

    logic [ROW_W-1:0] shaped;

    // Narrow shape returns one lane, zero-extended; wide returns the row.
    always_comb begin
        if (shape == SHAPE_NARROW) begin
            shaped = '0;
            shaped[LANE_W-1:0] = lane ? row_word[ROW_W-1:LANE_W]
                                      : row_word[LANE_W-1:0];
        end else begin
            shaped = row_word;
        end
    end

    // Load the word on a read; load zero when the tile is not selected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= sel ? shaped : '0;
        end
    end
endmodule

// File: rtl/shape_ram.sv
// Top: 256-bit two-port tile, switchable between 32x8 and 64x4.
// Assumes mode_narrow is static during traffic; contents survive a change.
module shape_ram
    import shape_ram_pkg::*;
#(
    parameter int WORD_W = 8,
    parameter int WORDS  = 32,
    localparam int ROW_AW = $clog2(WORDS),
    localparam int ADDR_W = ROW_AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_narrow,
    input  logic              blk_sel,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data
);
    localparam int LANE_W = WORD_W / LANES;

    shape_e              shape;
    logic [ROW_AW-1:0]   wr_row, rd_row;
    logic                wr_lane, rd_lane;
    logic [LANES-1:0]    lane_en;
    logic [WORD_W-1:0]   wr_word, row_word;

    assign shape = shape_e'(mode_narrow);

    shape_ram_decode #(.ROW_AW(ROW_AW)) u_wr_dec (
        .shape (shape), .addr (wr_addr), .row (wr_row), .lane (wr_lane)
    );

    shape_ram_decode #(.ROW_AW(ROW_AW)) u_rd_dec (
        .shape (shape), .addr (rd_addr), .row (rd_row), .lane (rd_lane)
    );

    // Build lane enables and write data for the current shape.
    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            if (shape == SHAPE_NARROW) begin
                lane_en[i] = wr_en && blk_sel && (wr_lane == i[0]);
                wr_word[i*LANE_W +: LANE_W] = wr_data[LANE_W-1:0];
            end else begin
                lane_en[i] = wr_en && blk_sel;
                wr_word[i*LANE_W +: LANE_W] = wr_data[i*LANE_W +: LANE_W];
            end
        end
    end

    shape_ram_array #(.ROWS(WORDS), .ROW_W(WORD_W)) u_array (
        .clk        (clk),
        .wr_row     (wr_row),
        .wr_lane_en (lane_en),
        .wr_word    (wr_word),
        .rd_row     (rd_row),
        .rd_word    (row_word)
    );

    shape_ram_rdport #(.ROW_W(WORD_W)) u_rdport (
        .clk      (clk),
        .rst_n    (rst_n),
        .shape    (shape),
        .lane     (rd_lane),
        .rd_en    (rd_en),
        .sel      (blk_sel),
        .row_word (row_word),
        .rd_data  (rd_data)
    );
endmodule

// File: rtl/shape_ram_chk.sv
// Checker: port-level timing rules of the tile, bound to every instance.
// Assumes rst_n is low at the first clock edge.
module shape_ram_chk #(
    parameter int WORD_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mode_narrow,
    input logic              blk_sel,
    input logic              rd_en,
    input logic [WORD_W-1:0] rd_data
);
    // R9
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> rd_data == '0);

    // R5
    idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

    // R7
    desel_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && !blk_sel |=> rd_data == '0);

    // R2
    narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && mode_narrow |=> rd_data[WORD_W-1:WORD_W/2] == '0);
endmodule

bind shape_ram shape_ram_chk #(.WORD_W(WORD_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_narrow (mode_narrow),
    .blk_sel     (blk_sel),
    .rd_en       (rd_en),
    .rd_data     (rd_data)
);

// File: tb/test_shape_ram.sv
// Directed bench: one task per scenario, each checking its own results.
module test_shape_ram;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_narrow = 1'b0;
    logic       blk_sel = 1'b1;
    logic       wr_en = 1'b0;
    logic [5:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [5:0] rd_addr = '0;
    logic [7:0] rd_data;

    int n_run = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    shape_ram i_shape_ram (
        .clk(clk), .rst_n(rst_n), .mode_narrow(mode_narrow), .blk_sel(blk_sel),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic check(string req, logic [7:0] got, logic [7:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(logic [5:0] a, logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [5:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        v = rd_data;
        check("R9 reset", v, 8'h00);
    endtask

    task automatic t_wide();
        logic [7:0] v;
        mode_narrow = 1'b0;
        for (int i = 0; i < 4; i++) wr(6'(i * 5), 8'(8'h3C + i * 8'h21));
        for (int i = 0; i < 4; i++) begin
            rd(6'(i * 5), v);
            check("R1 wide readback", v, 8'(8'h3C + i * 8'h21));
        end
        rd(6'h25, v);   // bit 5 ignored: same row as 5
        check("R1 bit5 ignored", v, 8'h5D);
    endtask

    task automatic t_latency();
        @(negedge clk);
        rd_en = 1'b1; rd_addr = 6'd0;
        #1 check("R4 no early change", rd_data, 8'h5D);
        @(posedge clk); #1;
        rd_en = 1'b0;
        check("R4 after edge", rd_data, 8'h3C);
    endtask

    task automatic t_hold();
        @(negedge clk);
        rd_addr = 6'd10;
        repeat (3) @(negedge clk);
        check("R5 hold while idle", rd_data, 8'h3C);
    endtask

    task automatic t_narrow();
        logic [7:0] v;
        mode_narrow = 1'b1;
        wr(6'd40, 8'hF3);      // row 20 low half, upper data bits ignored
        wr(6'd41, 8'h0A);      // row 20 high half
        rd(6'd40, v); check("R2 low half", v, 8'h03);
        rd(6'd41, v); check("R2 high half", v, 8'h0A);
        mode_narrow = 1'b0;
        rd(6'd20, v); check("R8 shape change keeps data", v, 8'hA3);
    endtask

    task automatic t_keep_half();
        logic [7:0] v;
        mode_narrow = 1'b0;
        wr(6'd7, 8'h5C);
        mode_narrow = 1'b1;
        wr(6'd14, 8'h09);      // row 7 low half
        mode_narrow = 1'b0;
        rd(6'd7, v); check("R3 other half kept (low write)", v, 8'h59);
        mode_narrow = 1'b1;
        wr(6'd15, 8'h0E);      // row 7 high half
        mode_narrow = 1'b0;
        rd(6'd7, v); check("R3 other half kept (high write)", v, 8'hE9);
    endtask

    task automatic t_collide();
        logic [7:0] v;
        wr(6'd3, 8'h11);
        wr(6'd5, 8'h77);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 6'd3; wr_data = 8'h22;
        rd_en = 1'b1; rd_addr = 6'd3;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        check("R6 old data on collision", rd_data, 8'h11);
        rd(6'd3, v); check("R6 write kept", v, 8'h22);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 6'd4; wr_data = 8'h66;
        rd_en = 1'b1; rd_addr = 6'd5;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        check("R10 parallel read", rd_data, 8'h77);
        rd(6'd4, v); check("R10 parallel write", v, 8'h66);
    endtask

    task automatic t_desel();
        logic [7:0] v;
        blk_sel = 1'b0;
        wr(6'd3, 8'hFF);
        rd(6'd3, v); check("R7 deselected read is zero", v, 8'h00);
        blk_sel = 1'b1;
        rd(6'd3, v); check("R7 deselected write ignored", v, 8'h22);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_wide();
        t_latency();
        t_hold();
        t_narrow();
        t_keep_half();
        t_collide();
        t_desel();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule